// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel output of a parallel LCD panel interface. Every timing quantity comes from configuration inputs. The horizontal position is counted in pixel clocks within a line. The vertical position is not counted in lines. It is a single linear frame counter of pixel clocks that starts at the leading edge of vertical sync and wraps at the frame length. The vertical sync length and the vertical active window are therefore absolute pixel-clock offsets on that counter. A skew value is added to both ends of the vertical active window.

Pixels arrive on a valid/ready stream. The block raises `pix_ready` in every cycle where data-enable is high, and only then. `pix_ready` never depends on `pix_valid`, so the source cannot stall the raster. A beat is consumed on any cycle where both signals are high. If `pix_ready` is high and `pix_valid` is low, the cycle is an underflow. In that cycle the output carries a fill colour when recovery is enabled, and the border colour otherwise. Outside the active window the border colour is driven.

The configuration is copied into a shadow set only at a frame boundary, or continuously while the block is idle. Clearing `enable` lets the current frame run to its end before the block stops. A one-cycle event marks the first pixel clock of every frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is held, `de`, `pix_ready`, `underflow` and `vsync_evt` are 0, and `hsync`, `vsync` and `pix_out` are 0. While idle (not running), `de`, `pix_ready` and `vsync_evt` stay 0.
- R2: Within each line of `cfg_line_len` clocks, hsync is active for the first `cfg_hs_width` clocks.
- R3: The frame counter runs from 0 to `cfg_frame_len`-1 and then wraps to 0. Vsync is active while the counter is below `cfg_vs_len`.
- R4: `de` is 1 exactly when two conditions hold. The line position must lie in [`cfg_hact_first`, `cfg_hact_last`]. The frame position must lie in [`cfg_vact_first`+`cfg_skew`, `cfg_vact_last`+`cfg_skew`].
- R5: When `cfg_hs_low` is 1 hsync is active-low, and when `cfg_vs_low` is 1 vsync is active-low. When idle, each sync output sits at its inactive level.
- R6: `pix_ready` equals `de`. When `pix_valid` is also 1, `pix_out` equals `pix_data` in the same cycle.
- R7: `underflow` is 1 when `pix_ready` is 1 and `pix_valid` is 0. In such a cycle `pix_out` is `cfg_fill` if `cfg_recover` is 1, and `cfg_border` otherwise.
- R8: When `de` is 0, `pix_out` is `cfg_border`.
- R9: After `enable` rises, the next cycle is frame position 0. When `enable` is low at the last clock of a frame, the block goes idle after that clock. A low `enable` earlier in the frame does not cut the frame short.
- R10: A configuration change made while running takes effect only from the next frame position 0.
- R11: `vsync_evt` is 1 for exactly one cycle, at frame position 0 of every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request, sampled at frame boundaries |
| cfg_line_len | input | 12 | Line period in pixel clocks |
| cfg_hs_width | input | 12 | Hsync pulse width |
| cfg_hact_first | input | 12 | First active line position |
| cfg_hact_last | input | 12 | Last active line position |
| cfg_frame_len | input | 24 | Frame period in pixel clocks |
| cfg_vs_len | input | 24 | Vsync length in pixel clocks |
| cfg_vact_first | input | 24 | First active frame position before skew |
| cfg_vact_last | input | 24 | Last active frame position before skew |
| cfg_skew | input | 12 | Offset added to the vertical window |
| cfg_hs_low | input | 1 | Hsync active-low |
| cfg_vs_low | input | 1 | Vsync active-low |
| cfg_recover | input | 1 | Use fill colour on underflow |
| cfg_border | input | 24 | Colour outside the active window |
| cfg_fill | input | 24 | Colour for underflowed pixels |
| pix_valid | input | 1 | Source has a pixel |
| pix_ready | output | 1 | Block takes a pixel this cycle |
| pix_data | input | 24 | Source pixel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | 24 | Pixel to panel |
| underflow | output | 1 | Active pixel missing this cycle |
| vsync_evt | output | 1 | Frame start pulse |

## Verification
The hardest cases to reach are configuration edits and disable requests that arrive in the middle of a frame. Each one has to be shown to stay invisible until the boundary and then to apply exactly at position 0. The stimulus applies each edit, or the drop of `enable`, at a chosen frame position. It then sweeps every pixel clock of the rest of that frame and of the following frame. The expected raster is computed from the configuration captured at the last clock of the previous frame. Underflow is produced by a valid pattern with periodic gaps, run once with recovery on and once with it off.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  parameter int H_W   = 12;
  parameter int F_W   = 24;
  parameter int PIX_W = 24;

  typedef struct packed {
    logic [H_W-1:0]   hper;
    logic [H_W-1:0]   hpulse;
    logic [H_W-1:0]   hstart;
    logic [H_W-1:0]   hend;
    logic [F_W-1:0]   fper;
    logic [F_W-1:0]   vpulse;
    logic [F_W-1:0]   vstart;
    logic [F_W-1:0]   vend;
    logic [H_W-1:0]   skew;
    logic             hs_low;
    logic             vs_low;
    logic             recov;
    logic [PIX_W-1:0] border;
    logic [PIX_W-1:0] fill;
  } lcd_cfg_t;
endpackage

// File: rtl/lcd_tg_shadow.sv
module lcd_tg_shadow
  import lcd_tg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  lcd_cfg_t cfg_in,
  output lcd_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/lcd_tg_counters.sv
module lcd_tg_counters
  import lcd_tg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [H_W-1:0] hper,
  input  logic [F_W-1:0] fper,
  output logic           run,
  output logic [H_W-1:0] hcnt,
  output logic [F_W-1:0] fcnt,
  output logic           frame_last
);
  localparam logic [H_W-1:0] H_ONE = H_W'(1);
  localparam logic [F_W-1:0] F_ONE = F_W'(1);

  logic line_last;
  assign line_last  = (hcnt == hper - H_ONE);
  assign frame_last = run && (fcnt == fper - F_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      hcnt <= '0;
      fcnt <= '0;
    end else if (!run) begin
      run  <= enable;
      hcnt <= '0;
      fcnt <= '0;
    end else if (frame_last) begin
      run  <= enable;
      hcnt <= '0;
      fcnt <= '0;
    end else begin
      fcnt <= fcnt + F_ONE;
      hcnt <= line_last ? '0 : hcnt + H_ONE;
    end
  end
endmodule

// File: rtl/lcd_tg_decode.sv
module lcd_tg_decode
  import lcd_tg_pkg::*;
(
  input  logic           run,
  input  logic [H_W-1:0] hcnt,
  input  logic [F_W-1:0] fcnt,
  input  logic [H_W-1:0] hpulse,
  input  logic [H_W-1:0] hstart,
  input  logic [H_W-1:0] hend,
  input  logic [F_W-1:0] vpulse,
  input  logic [F_W-1:0] vstart,
  input  logic [F_W-1:0] vend,
  input  logic [H_W-1:0] skew,
  input  logic           hs_low,
  input  logic           vs_low,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic           frame_evt
);
  logic [F_W-1:0] v_first, v_last;
  logic hs_act, vs_act, h_win, v_win;

  always_comb begin
    v_first   = vstart + F_W'(skew);
    v_last    = vend   + F_W'(skew);
    hs_act    = run && (hcnt < hpulse);
    vs_act    = run && (fcnt < vpulse);
    h_win     = (hcnt >= hstart) && (hcnt <= hend);
    v_win     = (fcnt >= v_first) && (fcnt <= v_last);
    de        = run && h_win && v_win;
    frame_evt = run && (fcnt == '0);
    hsync     = hs_act ^ hs_low;
    vsync     = vs_act ^ vs_low;
  end
endmodule

// File: rtl/lcd_tg_pixmux.sv
module lcd_tg_pixmux
  import lcd_tg_pkg::*;
(
  input  logic             de,
  input  logic             recov,
  input  logic [PIX_W-1:0] border,
  input  logic [PIX_W-1:0] fill,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             underflow,
  output logic [PIX_W-1:0] pix_out
);
  always_comb begin
    pix_ready = de;
    underflow = de && !pix_valid;
    if (!de)           pix_out = border;
    else if (pix_valid) pix_out = pix_data;
    else if (recov)    pix_out = fill;
    else               pix_out = border;
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [H_W-1:0]   cfg_line_len,
  input  logic [H_W-1:0]   cfg_hs_width,
  input  logic [H_W-1:0]   cfg_hact_first,
  input  logic [H_W-1:0]   cfg_hact_last,
  input  logic [F_W-1:0]   cfg_frame_len,
  input  logic [F_W-1:0]   cfg_vs_len,
  input  logic [F_W-1:0]   cfg_vact_first,
  input  logic [F_W-1:0]   cfg_vact_last,
  input  logic [H_W-1:0]   cfg_skew,
  input  logic             cfg_hs_low,
  input  logic             cfg_vs_low,
  input  logic             cfg_recover,
  input  logic [PIX_W-1:0] cfg_border,
  input  logic [PIX_W-1:0] cfg_fill,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [PIX_W-1:0] pix_out,
  output logic             underflow,
  output logic             vsync_evt
);
  lcd_cfg_t       cfg_in, sh;
  logic           run, frame_last, load;
  logic [H_W-1:0] hcnt;
  logic [F_W-1:0] fcnt;

  always_comb begin
    cfg_in.hper   = cfg_line_len;
    cfg_in.hpulse = cfg_hs_width;
    cfg_in.hstart = cfg_hact_first;
    cfg_in.hend   = cfg_hact_last;
    cfg_in.fper   = cfg_frame_len;
    cfg_in.vpulse = cfg_vs_len;
    cfg_in.vstart = cfg_vact_first;
    cfg_in.vend   = cfg_vact_last;
    cfg_in.skew   = cfg_skew;
    cfg_in.hs_low = cfg_hs_low;
    cfg_in.vs_low = cfg_vs_low;
    cfg_in.recov  = cfg_recover;
    cfg_in.border = cfg_border;
    cfg_in.fill   = cfg_fill;
  end

  assign load = !run || frame_last;

  lcd_tg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_in(cfg_in), .cfg_q(sh)
  );

  lcd_tg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hper(sh.hper), .fper(sh.fper),
    .run(run), .hcnt(hcnt), .fcnt(fcnt), .frame_last(frame_last)
  );

  lcd_tg_decode u_dec (
    .run(run), .hcnt(hcnt), .fcnt(fcnt),
    .hpulse(sh.hpulse), .hstart(sh.hstart), .hend(sh.hend),
    .vpulse(sh.vpulse), .vstart(sh.vstart), .vend(sh.vend),
    .skew(sh.skew), .hs_low(sh.hs_low), .vs_low(sh.vs_low),
    .hsync(hsync), .vsync(vsync), .de(de), .frame_evt(vsync_evt)
  );

  lcd_tg_pixmux u_pix (
    .de(de), .recov(sh.recov), .border(sh.border), .fill(sh.fill),
    .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .underflow(underflow), .pix_out(pix_out)
  );
endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk
  import lcd_tg_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic [F_W-1:0] fcnt,
  input lcd_cfg_t       sh,
  input logic           pix_valid,
  input logic           pix_ready,
  input logic           de,
  input logic           vsync,
  input logic           underflow,
  input logic           vsync_evt
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!de && !pix_ready && !vsync_evt));                       // R1
  AST_EVT_SYNC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_evt && sh.vpulse != '0) |-> (vsync != sh.vs_low));           // R3
  AST_READY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> de);                                                  // R6
  AST_UFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (pix_ready && !pix_valid));                           // R7
  AST_STOP_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(fcnt) == $past(sh.fper) - F_W'(1)));          // R9
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && fcnt != '0) |-> $stable(sh));                 // R10
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_evt && sh.fper > F_W'(1)) |=> !vsync_evt);                   // R11
endmodule

bind lcd_timing_gen lcd_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .fcnt(fcnt), .sh(sh),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .de(de), .vsync(vsync),
  .underflow(underflow), .vsync_evt(vsync_evt)
);

// File: tb/lcd_timing_gen_test.sv
`timescale 1ns/1ps
module lcd_timing_gen_test;
  import lcd_tg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic pix_valid = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic pix_ready, hsync, vsync, de, underflow, vsync_evt;
  logic [PIX_W-1:0] pix_out;
  lcd_cfg_t pc, ec, snap;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lcd_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_line_len(pc.hper), .cfg_hs_width(pc.hpulse),
    .cfg_hact_first(pc.hstart), .cfg_hact_last(pc.hend),
    .cfg_frame_len(pc.fper), .cfg_vs_len(pc.vpulse),
    .cfg_vact_first(pc.vstart), .cfg_vact_last(pc.vend),
    .cfg_skew(pc.skew), .cfg_hs_low(pc.hs_low), .cfg_vs_low(pc.vs_low),
    .cfg_recover(pc.recov), .cfg_border(pc.border), .cfg_fill(pc.fill),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
    .underflow(underflow), .vsync_evt(vsync_evt)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // One full frame; at position chg_at the drive config becomes nxt and enable en_nxt.
  task automatic run_frame(int mode, int chg_at, lcd_cfg_t nxt, logic en_nxt);
    ec = snap;
    for (int fc = 0; fc < int'(ec.fper); fc++) begin
      int hc;
      logic e_de, e_hs, e_vs;
      logic [PIX_W-1:0] e_pix;
      @(negedge clk);
      if (fc == chg_at) begin pc = nxt; enable = en_nxt; end
      pix_valid = (mode == 0) ? 1'b1 : ((fc % 3) != 1);
      pix_data  = PIX_W'(32'h400000 + fc);
      #1;
      hc   = fc % int'(ec.hper);
      e_hs = (hc < int'(ec.hpulse)) ^ ec.hs_low;
      e_vs = (fc < int'(ec.vpulse)) ^ ec.vs_low;
      e_de = (hc >= int'(ec.hstart)) && (hc <= int'(ec.hend)) &&
             (fc >= int'(ec.vstart) + int'(ec.skew)) &&
             (fc <= int'(ec.vend) + int'(ec.skew));
      if (!e_de)          e_pix = ec.border;
      else if (pix_valid) e_pix = pix_data;
      else if (ec.recov)  e_pix = ec.fill;
      else                e_pix = ec.border;
      chk("R2/R5", "hsync", 32'(hsync), 32'(e_hs));
      chk("R3/R5", "vsync", 32'(vsync), 32'(e_vs));
      chk("R4/R10", "de", 32'(de), 32'(e_de));
      chk("R6", "pix_ready", 32'(pix_ready), 32'(e_de));
      chk("R6/R7/R8", "pix_out", 32'(pix_out), 32'(e_pix));
      chk("R7", "underflow", 32'(underflow), 32'(e_de && !pix_valid));
      chk("R11", "vsync_evt", 32'(vsync_evt), 32'(fc == 0));
      if (fc == int'(ec.fper) - 1) snap = pc;
    end
  endtask

  task automatic idle_check(string req, logic [PIX_W-1:0] e_pix, logic hl, logic vl);
    @(negedge clk); #1;
    chk(req, "idle de", 32'(de), 32'd0);
    chk(req, "idle pix_ready", 32'(pix_ready), 32'd0);
    chk(req, "idle vsync_evt", 32'(vsync_evt), 32'd0);
    chk(req, "idle hsync", 32'(hsync), 32'(hl));
    chk(req, "idle vsync", 32'(vsync), 32'(vl));
    chk(req, "idle pix_out", 32'(pix_out), 32'(e_pix));
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    lcd_cfg_t nx;
    pc = '0;
    pc.hper = 8;  pc.hpulse = 2; pc.hstart = 3; pc.hend = 6;
    pc.fper = 48; pc.vpulse = 8; pc.vstart = 16; pc.vend = 39;
    pc.skew = 0;  pc.border = 24'h000033; pc.fill = 24'h0000FF;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "rst de", 32'(de), 0);
    chk("R1", "rst pix_ready", 32'(pix_ready), 0);
    chk("R1", "rst underflow", 32'(underflow), 0);
    chk("R1", "rst vsync_evt", 32'(vsync_evt), 0);
    chk("R1", "rst hsync", 32'(hsync), 0);
    chk("R1", "rst vsync", 32'(vsync), 0);
    chk("R1", "rst pix_out", 32'(pix_out), 0);
    rst_n = 1'b1;
    repeat (2) idle_check("R1", pc.border, 1'b0, 1'b0);
    // R9: start; first frame begins at position 0
    @(negedge clk); enable = 1'b1; snap = pc;
    run_frame(0, -1, pc, 1'b1);
    // R10: mid-frame edit, applies next frame
    nx = pc; nx.hend = 5; nx.recov = 1'b1;
    run_frame(0, 20, nx, 1'b1);
    run_frame(1, -1, pc, 1'b1);                 // R7 with recovery
    nx = pc; nx.recov = 1'b0; nx.border = 24'h0000AA;
    nx.hs_low = 1'b1; nx.vs_low = 1'b1; nx.skew = 3; nx.vpulse = 16;
    run_frame(1, 5, nx, 1'b1);
    run_frame(1, -1, pc, 1'b1);                 // R5, R4 skew, R7 without recovery
    // R9: disable mid-frame; frame completes, then idle
    run_frame(0, 10, pc, 1'b0);
    repeat (3) idle_check("R9/R5", pc.border, 1'b1, 1'b1);
    // R9: restart at position 0
    @(negedge clk); enable = 1'b1; snap = pc;
    run_frame(0, -1, pc, 1'b1);
    summary();
  end
endmodule